// File: doc/BRIEF.md
# Tug-of-War Light Game Controller

This block runs a two-player button game on a row of lights. Exactly one light is lit at any time. At reset the centre light is lit. Each press by the left player moves the lit position one step toward the left end of the row, and each press by the right player moves it one step toward the right end. Every raw button line first passes through a synchronizer and then through an edge detector. The edge detector gives one pulse per press, however long the button is held. If both players press in the same cycle, the result is a tie and nothing moves.

The position is not kept in a single shift register. Each light has its own one-bit state machine. Its next state depends only on its two neighbours and on the two press pulses. A win is not declared when the light merely reaches an end. A player wins only by pressing again, alone, while the end light on their own side is lit. The result is then latched and shown on a seven-segment digit. The lights freeze and all further presses are ignored until reset. Reset is asynchronous and active low, and it is released synchronously inside the block.

Top module: `rope_game_top`

## Requirements
- R1: After reset only light index NLAMP/2 (the centre) is lit, and `seg_o` shows a dash (segment g only, 7'b1000000, where bit 0 is segment a and bit 6 is segment g).
- R2: One press moves the light by exactly one step, however many cycles the button is held. No further movement happens until the button is released and pressed again.
- R3: A left-only press moves the lit light from index i to index i+1. Index NLAMP-1 is the left end. A right-only press moves it from index i to index i-1. Index 0 is the right end.
- R4: When both press pulses occur in the same cycle, the lights do not change and no winner is declared, also at an end light.
- R5: Exactly one light is lit in every cycle after reset.
- R6: Reaching index NLAMP-1 is not a win by itself. A left-only press while index NLAMP-1 is lit declares the left player the winner. `seg_o` then shows L (segments d, e, f: 7'b0111000).
- R7: A right-only press while index 0 is lit declares the right player the winner. `seg_o` then shows r (segments e, g: 7'b1010000).
- R8: Once a winner is declared, the lights and `seg_o` hold their values and all presses are ignored until reset.
- R9: A raw press first sampled at clock edge k changes the lights at edge k+2. The lights are unchanged after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| btn_left_raw | input | 1 | Left player button, asynchronous, high while pressed |
| btn_right_raw | input | 1 | Right player button, asynchronous, high while pressed |
| lamp_o | output | NLAMP | Light lines; index NLAMP-1 is the left end, index 0 the right end |
| seg_o | output | 7 | Seven-segment pattern, active high, bit 0 = segment a through bit 6 = segment g |

## Verification
The bench builds the block with its default values: nine lights and a two-stage synchronizer. With nine lights, an end is four presses from the centre, so both wins, a tie at an end light and the freeze after a win can all be reached in a few hundred cycles. Keeping the two-stage synchronizer makes the three-edge press latency exact, so the bench can check it cycle by cycle. A held button, a same-cycle double press and presses after a win are each driven at the ports, and a lit-count monitor runs on every cycle.

// File: rtl/rope_game_pkg.sv
package rope_game_pkg;

  localparam int SEG_W = 7;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'b00,
    WIN_LEFT  = 2'b01,
    WIN_RIGHT = 2'b10
  } winner_e;

  localparam logic [SEG_W-1:0] SEG_DASH  = 7'b1000000;
  localparam logic [SEG_W-1:0] SEG_LEFT  = 7'b0111000;
  localparam logic [SEG_W-1:0] SEG_RIGHT = 7'b1010000;

  function automatic logic [SEG_W-1:0] seg_of(winner_e w);
    case (w)
      WIN_LEFT:  return SEG_LEFT;
      WIN_RIGHT: return SEG_RIGHT;
      default:   return SEG_DASH;
    endcase
  endfunction

endpackage

// File: rtl/press_pulse.sv
module press_pulse #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic pulse_o
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], raw_i};
    prev_d = sync_q[TOP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign pulse_o = sync_q[TOP] & ~prev_q;

  // R2: a press produces a single-cycle pulse
  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

endmodule

// File: rtl/lamp_cell.sv
module lamp_cell #(
  parameter bit ON_AT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_l,
  input  logic step_r,
  input  logic nb_lower,
  input  logic nb_upper,
  output logic lit_o
);

  logic lit_q, lit_d;

  always_comb begin
    lit_d = lit_q;
    if (step_l)      lit_d = nb_lower;
    else if (step_r) lit_d = nb_upper;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lit_q <= ON_AT_RESET;
    else        lit_q <= lit_d;
  end

  assign lit_o = lit_q;

  // R4: the two step requests never coincide
  assert_step_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_l && step_r));

endmodule

// File: rtl/victory_unit.sv
module victory_unit
  import rope_game_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             left_only,
  input  logic             right_only,
  input  logic             end_left_lit,
  input  logic             end_right_lit,
  output logic             freeze_o,
  output logic [SEG_W-1:0] seg_o
);

  winner_e win_q, win_d;
  logic    hit_l, hit_r;

  always_comb begin
    hit_l = (win_q == WIN_NONE) & left_only  & end_left_lit;
    hit_r = (win_q == WIN_NONE) & right_only & end_right_lit;
    win_d = win_q;
    if (hit_l)      win_d = WIN_LEFT;
    else if (hit_r) win_d = WIN_RIGHT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= WIN_NONE;
    else        win_q <= win_d;
  end

  assign freeze_o = (win_q != WIN_NONE) | hit_l | hit_r;
  assign seg_o    = seg_of(win_q);

  // R8: a declared winner never changes
  assert_win_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != WIN_NONE) |=> (win_q == $past(win_q)));

  // R6: no winner without a single-sided press at an end light
  assert_no_win_on_reach_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_q == WIN_NONE) && !(left_only && end_left_lit) && !(right_only && end_right_lit))
      |=> (win_q == WIN_NONE));

endmodule

// File: rtl/rope_game_top.sv
module rope_game_top
  import rope_game_pkg::*;
#(
  parameter int NLAMP       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_left_raw,
  input  logic             btn_right_raw,
  output logic [NLAMP-1:0] lamp_o,
  output logic [SEG_W-1:0] seg_o
);

  localparam int CENTER = NLAMP / 2;
  localparam int LEND   = NLAMP - 1;

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i_n = rst_pipe_q[1];

  logic pulse_l, pulse_r;
  logic left_only, right_only;
  logic freeze;
  logic step_l, step_r;
  logic [NLAMP-1:0] lamp;

  press_pulse #(.SYNC_STAGES(SYNC_STAGES)) u_press_l (
    .clk(clk), .rst_n(rst_i_n), .raw_i(btn_left_raw), .pulse_o(pulse_l));

  press_pulse #(.SYNC_STAGES(SYNC_STAGES)) u_press_r (
    .clk(clk), .rst_n(rst_i_n), .raw_i(btn_right_raw), .pulse_o(pulse_r));

  always_comb begin
    left_only  = pulse_l & ~pulse_r;
    right_only = pulse_r & ~pulse_l;
    step_l     = left_only  & ~freeze;
    step_r     = right_only & ~freeze;
  end

  victory_unit u_victory (
    .clk(clk), .rst_n(rst_i_n),
    .left_only(left_only), .right_only(right_only),
    .end_left_lit(lamp[LEND]), .end_right_lit(lamp[0]),
    .freeze_o(freeze), .seg_o(seg_o));

  for (genvar i = 0; i < NLAMP; i++) begin : g_cell
    logic lower_nb, upper_nb;
    if (i == 0) begin : g_rend
      assign lower_nb = 1'b0;
    end else begin : g_rmid
      assign lower_nb = lamp[i-1];
    end
    if (i == LEND) begin : g_lend
      assign upper_nb = 1'b0;
    end else begin : g_lmid
      assign upper_nb = lamp[i+1];
    end
    lamp_cell #(.ON_AT_RESET(i == CENTER)) u_cell (
      .clk(clk), .rst_n(rst_i_n),
      .step_l(step_l), .step_r(step_r),
      .nb_lower(lower_nb), .nb_upper(upper_nb),
      .lit_o(lamp[i]));
  end

  assign lamp_o = lamp;

  // R5: exactly one light lit
  assert_one_lit_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    $countones(lamp) == 1);

  // R3: a left step shifts the lit light up by one
  assert_move_left_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    step_l |=> (lamp == ($past(lamp) << 1)));

  // R3: a right step shifts the lit light down by one
  assert_move_right_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    step_r |=> (lamp == ($past(lamp) >> 1)));

  // R4: simultaneous pulses leave the lights unchanged
  assert_tie_hold_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pulse_l && pulse_r) |=> $stable(lamp));

  // R8: after a win lights and display are frozen
  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (seg_o != SEG_DASH) |=> ($stable(lamp) && $stable(seg_o)));

endmodule

// File: tb/sim_rope_game_top.sv
`timescale 1ns/1ps
module sim_rope_game_top;

  localparam int NL = 9;
  localparam logic [6:0] DASH = 7'b1000000;
  localparam logic [6:0] SEGL = 7'b0111000;
  localparam logic [6:0] SEGR = 7'b1010000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bl = 1'b0;
  logic br = 1'b0;
  logic [NL-1:0] lamp;
  logic [6:0] seg;

  int checks = 0;
  int failures = 0;
  int bad_lit = 0;
  int pos = NL / 2;

  always #2 clk = ~clk;

  rope_game_top #(.NLAMP(NL), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .btn_left_raw(bl), .btn_right_raw(br),
    .lamp_o(lamp), .seg_o(seg));

  always @(negedge clk)
    if (rst_n && $countones(lamp) != 1) bad_lit++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] onelit(input int p);
    return 32'(1) << p;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    bl = 1'b0; br = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    pos = NL / 2;
  endtask

  task automatic press(input logic l, input logic r, input int hold);
    @(negedge clk);
    bl = l; br = r;
    repeat (hold) @(posedge clk);
    @(negedge clk);
    bl = 1'b0; br = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 centre lit", 32'(lamp), onelit(NL / 2));
    chk("R1 dash", 32'(seg), 32'(DASH));
  endtask

  task automatic t_latency_and_hold();
    do_reset();
    bl = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9 unchanged after second edge", 32'(lamp), onelit(pos));
    @(posedge clk); @(negedge clk);
    pos++;
    chk("R9 moved at third edge", 32'(lamp), onelit(pos));
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk("R2 held button moves once", 32'(lamp), onelit(pos));
    bl = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R2 release no move", 32'(lamp), onelit(pos));
  endtask

  task automatic t_right_steps();
    for (int k = 0; k < 3; k++) begin
      press(1'b0, 1'b1, 7);
      pos--;
      chk("R3 right step", 32'(lamp), onelit(pos));
    end
    press(1'b1, 1'b0, 1);
    pos++;
    chk("R3 left step", 32'(lamp), onelit(pos));
  endtask

  task automatic t_tie();
    press(1'b1, 1'b1, 6);
    chk("R4 tie no move", 32'(lamp), onelit(pos));
    chk("R4 tie no winner", 32'(seg), 32'(DASH));
  endtask

  task automatic t_left_win();
    do_reset();
    for (int k = 0; k < NL / 2; k++) press(1'b1, 1'b0, 2);
    pos = NL - 1;
    chk("R6 reached left end", 32'(lamp), onelit(pos));
    chk("R6 reaching is no win", 32'(seg), 32'(DASH));
    press(1'b1, 1'b1, 3);
    chk("R4 tie at end no win", 32'(seg), 32'(DASH));
    press(1'b1, 1'b0, 2);
    chk("R6 left wins", 32'(seg), 32'(SEGL));
    chk("R6 light stays at end", 32'(lamp), onelit(pos));
    press(1'b0, 1'b1, 2);
    chk("R8 right press ignored lights", 32'(lamp), onelit(pos));
    chk("R8 right press ignored seg", 32'(seg), 32'(SEGL));
    press(1'b1, 1'b0, 2);
    chk("R8 left press ignored", 32'(lamp), onelit(pos));
  endtask

  task automatic t_right_win();
    do_reset();
    for (int k = 0; k < NL / 2; k++) press(1'b0, 1'b1, 2);
    pos = 0;
    chk("R7 reached right end", 32'(lamp), onelit(pos));
    chk("R7 reaching is no win", 32'(seg), 32'(DASH));
    press(1'b0, 1'b1, 2);
    chk("R7 right wins", 32'(seg), 32'(SEGR));
    press(1'b1, 1'b0, 2);
    chk("R8 left press ignored after right win", 32'(lamp), onelit(pos));
    chk("R8 seg held", 32'(seg), 32'(SEGR));
    do_reset();
    chk("R1 reset clears win", 32'(seg), 32'(DASH));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_latency_and_hold();
    t_right_steps();
    t_tie();
    t_left_win();
    t_right_win();
    chk("R5 one light every cycle", 32'(bad_lit), 32'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule